// File: doc/BRIEF.md
# General-purpose I/O port with per-pin interrupts

This block is a memory-mapped I/O port with a configurable number of pins (16 by default) on a simple 32-bit, zero-wait-state peripheral bus. Each pin has an output value, an output enable and a selector that hands the pad to an alternate function instead of the main function. The port samples the pad inputs through a two-flop synchroniser, and software reads the sampled levels back.

Every pin can raise an interrupt. The interrupt is either level-sensitive or edge-sensitive, and its polarity selects high level or rising edge, or low level or falling edge. The enabled per-pin status bits are combined into one processor interrupt line. Software changes the configuration bitmaps through paired set and clear addresses, so it never needs a read-modify-write. The interrupt status is read and cleared at one shared address. A block of fixed identification words sits at the top of the 4 KiB window.

A bus write takes effect on the rising clock edge where `req_i` and `we_i` are both high. Read data is combinational from `addr_i` while `req_i` is high and `we_i` is low, and is zero otherwise.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch, output enables, alternate selects, interrupt enables, types, polarities and status are all zero, so `pin_o`, `pin_oe_o`, `alt_sel_o`, `irq_pin_o` and `irq_o` are zero.
- R2: Offset 0x004 is a plain read/write output latch. Its low NPINS bits drive `pin_o` and read back unchanged.
- R3: Output enable uses set address 0x010 and clear address 0x014. Alternate select uses set address 0x018 and clear address 0x01C. A 1 in a written bit sets (or clears) that pin's bit and a 0 leaves it unchanged. Reading either address of a pair returns the bitmap, which drives `pin_oe_o` or `alt_sel_o`.
- R4: Offset 0x000 reads the pin inputs after a two-flop synchroniser. A pin change made between two rising edges is not visible after the first of the following edges, and is visible after the second.
- R5: Interrupt enable, type and polarity follow the set/clear rule of R3 at 0x020/0x024, 0x028/0x02C and 0x030/0x034. A type bit of 1 selects edge mode and 0 selects level mode. A polarity bit of 1 selects high level or rising edge, and 0 selects low level or falling edge.
- R6: In edge mode, an enabled pin's status bit (read at 0x038) sets on a qualifying edge and holds until a 1 is written to that bit at 0x038. Writing 0 bits leaves it unchanged, and edges on a disabled pin are not captured.
- R7: In level mode, the status bit follows the qualified input level while the pin is enabled and is zero while it is disabled. A clear write to 0x038 has no lasting effect on it.
- R8: `irq_pin_o` is the status bitmap masked by the interrupt enables, and `irq_o` is high exactly when any bit of `irq_pin_o` is set.
- R9: The words at 0xFD0 to 0xFF0 read the constants 0x04, 0x51, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order, and writes to them are ignored.
- R10: Unmapped offsets (for example 0x008, 0x00C, 0x03C) read zero and writes to them change no register. Bits at or above NPINS read zero and are ignored on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| pin_i | input | NPINS | Pad input levels |
| pin_o | output | NPINS | Output latch value |
| pin_oe_o | output | NPINS | Per-pin output enable |
| alt_sel_o | output | NPINS | Per-pin alternate-function select |
| irq_pin_o | output | NPINS | Enabled per-pin interrupt status |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the difference between a latched edge status and a live level status on the same status address. For edges, the bench checks that the bit survives the pin returning to idle and a write of zeros, and is removed only by a one. For levels, it checks that a clear write changes nothing while the level persists. The stimulus orders the configuration writes (type and polarity before enable) so that no spurious level status appears. It then moves single pins between bus accesses, waiting enough edges for the synchroniser and the previous-sample flop. Edges on a disabled pin and a polarity flip under a steady level are covered as well.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] OFS_DIN   = 12'h000;
  localparam logic [AW-1:0] OFS_DOUT  = 12'h004;
  localparam logic [AW-1:0] OFS_CFG0  = 12'h010;
  localparam logic [AW-1:0] OFS_ISTAT = 12'h038;
  localparam logic [AW-1:0] OFS_ID0   = 12'hFD0;

  // configuration bitmaps in set/clear address order
  localparam int unsigned CFG_OE   = 0;
  localparam int unsigned CFG_ALT  = 1;
  localparam int unsigned CFG_IEN  = 2;
  localparam int unsigned CFG_ITYP = 3;
  localparam int unsigned CFG_IPOL = 4;
  localparam int unsigned CFG_NUM  = 5;
  localparam int unsigned ID_NUM   = 9;

  function automatic logic [AW-1:0] cfg_set_addr(int unsigned k);
    return AW'(OFS_CFG0 + AW'(8 * k));
  endfunction

  function automatic logic [AW-1:0] cfg_clr_addr(int unsigned k);
    return AW'(OFS_CFG0 + AW'(8 * k + 4));
  endfunction

  function automatic logic [DW-1:0] id_word(int unsigned k);
    case (k)
      0: return 32'h04;
      1: return 32'h51;
      2: return 32'hB8;
      3: return 32'h1B;
      4: return 32'h00;
      5: return 32'h0D;
      6: return 32'hF0;
      7: return 32'h05;
      8: return 32'hB1;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_port_sc_reg.sv
module gpio_port_sc_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q | (set_i ? wdata_i : '0)) & ~(clr_i ? wdata_i : '0);
  end

  assign q_o = q;

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/gpio_port_irq_bit.sv
module gpio_port_irq_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic status_o
);
  logic prev_q, status_q, hit, evt;

  assign hit = rise_i ? lvl_i : ~lvl_i;
  assign evt = rise_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (edge_mode_i) status_q <= (status_q & ~clr_i) | (en_i & evt);
      else             status_q <= en_i & hit;
    end
  end

  assign status_o = status_q;

  assert_edge_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && status_q && !clr_i) |=> status_q);

  assert_edge_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && !status_q && !en_i) |=> !status_q);

  assert_level_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && !en_i) |=> !status_q);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic [NPINS-1:0] alt_sel_o,
  output logic [NPINS-1:0] irq_pin_o,
  output logic             irq_o
);
  localparam logic [AW-1:0] ID_LAST = AW'(OFS_ID0 + AW'(4 * (ID_NUM - 1)));

  logic                          wr;
  logic [NPINS-1:0]              wdata_w, din_s, dout_q, istat, istat_clr;
  logic [CFG_NUM-1:0][NPINS-1:0] cfg_q;
  logic                          mapped;
  logic                          unused_wdata;

  assign wr           = req_i & we_i;
  assign wdata_w      = wdata_i[NPINS-1:0];
  assign unused_wdata = ^wdata_i;

  gpio_port_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (din_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      dout_q <= '0;
    else if (wr && addr_i == OFS_DOUT) dout_q <= wdata_w;
  end

  for (genvar k = 0; k < CFG_NUM; k++) begin : g_cfg
    gpio_port_sc_reg #(.W(NPINS)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr && addr_i == cfg_set_addr(k)),
      .clr_i  (wr && addr_i == cfg_clr_addr(k)),
      .wdata_i(wdata_w),
      .q_o    (cfg_q[k])
    );
  end

  assign istat_clr = (wr && addr_i == OFS_ISTAT) ? wdata_w : '0;

  for (genvar i = 0; i < NPINS; i++) begin : g_irq
    gpio_port_irq_bit u_bit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (din_s[i]),
      .en_i       (cfg_q[CFG_IEN][i]),
      .edge_mode_i(cfg_q[CFG_ITYP][i]),
      .rise_i     (cfg_q[CFG_IPOL][i]),
      .clr_i      (istat_clr[i]),
      .status_o   (istat[i])
    );
  end

  // read decode; mapped also qualifies writes for the checker below
  always_comb begin
    rdata_o = '0;
    mapped  = 1'b0;
    if (addr_i == OFS_DIN) begin
      mapped  = 1'b1;
      rdata_o = DW'(din_s);
    end else if (addr_i == OFS_DOUT) begin
      mapped  = 1'b1;
      rdata_o = DW'(dout_q);
    end else if (addr_i == OFS_ISTAT) begin
      mapped  = 1'b1;
      rdata_o = DW'(istat);
    end else if (addr_i >= OFS_ID0 && addr_i <= ID_LAST && addr_i[1:0] == 2'b00) begin
      mapped  = 1'b1;
      rdata_o = id_word(32'(addr_i - OFS_ID0) >> 2);
    end
    for (int unsigned k = 0; k < CFG_NUM; k++) begin
      if (addr_i == cfg_set_addr(k) || addr_i == cfg_clr_addr(k)) begin
        mapped  = 1'b1;
        rdata_o = DW'(cfg_q[k]);
      end
    end
    if (!req_i || we_i) rdata_o = '0;
  end

  assign pin_o     = dout_q;
  assign pin_oe_o  = cfg_q[CFG_OE];
  assign alt_sel_o = cfg_q[CFG_ALT];
  assign irq_pin_o = istat & cfg_q[CFG_IEN];
  assign irq_o     = |irq_pin_o;

  assert_unmapped_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !mapped) |=> ($stable(cfg_q) && $stable(dout_q)));

  assert_id_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i >= OFS_ID0) |=> ($stable(cfg_q) && $stable(dout_q)));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int unsigned NPINS = 16;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 38;
  // R2 latch, R3 set/clear pairs, R5 irq config pairs, R10 unmapped, R9 identification
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h004, 32'hDEADBEEF, 32'h0, 4'd2},
    '{1'b0, 12'h004, 32'h0, 32'h0000BEEF, 4'd2},
    '{1'b1, 12'h010, 32'h000000FF, 32'h0, 4'd3},
    '{1'b0, 12'h010, 32'h0, 32'h000000FF, 4'd3},
    '{1'b0, 12'h014, 32'h0, 32'h000000FF, 4'd3},
    '{1'b1, 12'h014, 32'h0000000F, 32'h0, 4'd3},
    '{1'b0, 12'h010, 32'h0, 32'h000000F0, 4'd3},
    '{1'b1, 12'h010, 32'h00010100, 32'h0, 4'd3},
    '{1'b0, 12'h014, 32'h0, 32'h000001F0, 4'd3},
    '{1'b1, 12'h018, 32'h00008001, 32'h0, 4'd3},
    '{1'b0, 12'h01C, 32'h0, 32'h00008001, 4'd3},
    '{1'b1, 12'h01C, 32'h00000001, 32'h0, 4'd3},
    '{1'b0, 12'h018, 32'h0, 32'h00008000, 4'd3},
    '{1'b1, 12'h020, 32'h00000300, 32'h0, 4'd5},
    '{1'b0, 12'h024, 32'h0, 32'h00000300, 4'd5},
    '{1'b1, 12'h028, 32'h00000003, 32'h0, 4'd5},
    '{1'b1, 12'h02C, 32'h00000002, 32'h0, 4'd5},
    '{1'b0, 12'h028, 32'h0, 32'h00000001, 4'd5},
    '{1'b1, 12'h030, 32'h0000FFFF, 32'h0, 4'd5},
    '{1'b1, 12'h034, 32'h000000FF, 32'h0, 4'd5},
    '{1'b0, 12'h030, 32'h0, 32'h0000FF00, 4'd5},
    '{1'b1, 12'h008, 32'hFFFFFFFF, 32'h0, 4'd10},
    '{1'b0, 12'h008, 32'h0, 32'h0, 4'd10},
    '{1'b0, 12'h00C, 32'h0, 32'h0, 4'd10},
    '{1'b0, 12'h03C, 32'h0, 32'h0, 4'd10},
    '{1'b0, 12'h004, 32'h0, 32'h0000BEEF, 4'd10},
    '{1'b0, 12'hFD0, 32'h0, 32'h04, 4'd9},
    '{1'b0, 12'hFD4, 32'h0, 32'h51, 4'd9},
    '{1'b0, 12'hFD8, 32'h0, 32'hB8, 4'd9},
    '{1'b0, 12'hFDC, 32'h0, 32'h1B, 4'd9},
    '{1'b0, 12'hFE0, 32'h0, 32'h00, 4'd9},
    '{1'b0, 12'hFE4, 32'h0, 32'h0D, 4'd9},
    '{1'b0, 12'hFE8, 32'h0, 32'hF0, 4'd9},
    '{1'b0, 12'hFEC, 32'h0, 32'h05, 4'd9},
    '{1'b0, 12'hFF0, 32'h0, 32'hB1, 4'd9},
    '{1'b1, 12'hFD4, 32'h0, 32'h0, 4'd9},
    '{1'b0, 12'hFD4, 32'h0, 32'h51, 4'd9},
    '{1'b0, 12'h010, 32'h0, 32'h000001F0, 4'd10}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0, we = 1'b0;
  logic [11:0]      addr = '0;
  logic [31:0]      wdata = '0, rdata;
  logic [NPINS-1:0] pins = '0;
  logic [NPINS-1:0] pin_o, pin_oe_o, alt_sel_o, irq_pin_o;
  logic             irq_o;
  int               checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_port #(.NPINS(NPINS)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .req_i    (req),
    .we_i     (we),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pin_i    (pins),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o),
    .alt_sel_o(alt_sel_o),
    .irq_pin_o(irq_pin_o),
    .irq_o    (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pins  = '0;
    tick(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R1 reset state
    check("R1 pin_o", 32'(pin_o), 32'h0);
    check("R1 pin_oe_o", 32'(pin_oe_o), 32'h0);
    check("R1 irq_o", 32'(irq_o), 32'h0);
    read_check("R1 ien", 12'h020, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) bus_write(VECS[v].addr, VECS[v].data);
      else read_check($sformatf("R%0d vec%0d", VECS[v].rq, v), VECS[v].addr, VECS[v].exp);
    end

    check("R2 pin_o", 32'(pin_o), 32'h0000BEEF);
    check("R3 pin_oe_o", 32'(pin_oe_o), 32'h000001F0);
    check("R3 alt_sel_o", 32'(alt_sel_o), 32'h00008000);

    do_reset();
    check("R1 pin_oe_o after reapply", 32'(pin_oe_o), 32'h0);
    check("R1 irq_pin_o", 32'(irq_pin_o), 32'h0);
    read_check("R1 istat", 12'h038, 32'h0);

    // R4 synchroniser latency
    @(negedge clk);
    pins = 16'h00F0;
    read_check("R4 one edge", 12'h000, 32'h0);
    read_check("R4 two edges", 12'h000, 32'h000000F0);

    // R6 rising edge on pin 0: type and polarity before enable
    bus_write(12'h028, 32'h1);
    bus_write(12'h030, 32'h1);
    bus_write(12'h020, 32'h1);
    pins[0] = 1'b1;
    tick(3);
    read_check("R6 rise captured", 12'h038, 32'h1);
    check("R8 irq_o on edge", 32'(irq_o), 32'h1);
    pins[0] = 1'b0;
    tick(4);
    read_check("R6 hold after pin idle", 12'h038, 32'h1);
    bus_write(12'h038, 32'h0000FFFE);
    read_check("R6 zero bits keep", 12'h038, 32'h1);
    bus_write(12'h038, 32'h1);
    read_check("R6 cleared", 12'h038, 32'h0);
    check("R8 irq_o after clear", 32'(irq_o), 32'h0);

    // R6 falling edge on pin 1
    bus_write(12'h028, 32'h2);
    bus_write(12'h020, 32'h2);
    pins[1] = 1'b1;
    tick(4);
    read_check("R6 rise ignored in falling mode", 12'h038, 32'h0);
    pins[1] = 1'b0;
    tick(4);
    read_check("R6 fall captured", 12'h038, 32'h2);
    check("R8 irq_pin_o", 32'(irq_pin_o), 32'h2);
    bus_write(12'h038, 32'h2);

    // R6 edge on disabled pin not captured
    bus_write(12'h024, 32'h1);
    pins[0] = 1'b1;
    tick(4);
    pins[0] = 1'b0;
    tick(4);
    read_check("R6 masked edge", 12'h038, 32'h0);

    // R7 level on pin 4 (high)
    bus_write(12'h030, 32'h10);
    bus_write(12'h020, 32'h10);
    tick(2);
    read_check("R7 high level", 12'h038, 32'h10);
    check("R8 irq_o level", 32'(irq_o), 32'h1);
    check("R8 irq_pin_o level", 32'(irq_pin_o), 32'h10);
    bus_write(12'h038, 32'h10);
    tick(1);
    read_check("R7 clear has no lasting effect", 12'h038, 32'h10);
    pins[4] = 1'b0;
    tick(4);
    read_check("R7 level dropped", 12'h038, 32'h0);
    bus_write(12'h034, 32'h10);
    tick(2);
    read_check("R7 low polarity", 12'h038, 32'h10);
    bus_write(12'h024, 32'h10);
    tick(2);
    read_check("R7 disabled", 12'h038, 32'h0);
    check("R8 irq_o idle", 32'(irq_o), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule